// File: doc/BRIEF.md
# Watchdog Timer with Shared Prescaler

This block watches for a stalled program. An 8-bit base counter advances on each tick of a free-running watchdog oscillator, supplied here as a one-cycle enable. The watchdog keeps counting while the rest of the device sleeps. Software must pulse a clear strobe, or enter sleep through the sleep strobe, before the counter runs out. When the count expires while the device is awake, the block requests a device reset. When it expires while the device is asleep, it requests a wake-up, and normal operation continues.

One 8-stage binary divider is shared with a general-purpose timer. An owner-select input decides which side uses it. With the watchdog as owner, the divider stretches the watchdog period by a power of two. With the timer as owner, the divider slows the timer's source pulses, and the watchdog runs at its base period. A 3-bit ratio code picks the divider tap. An enable strap held low turns the watchdog off for good.

Top module: `wdt_psc_watchdog`

## Requirements
- R1: With `psc_owner`=1 and ratio code k (0..7), a time-out occurs after 256·2^k oscillator ticks counted from a clear. The ratios run from 1:1 for code 0 up to 1:128 for code 7.
- R2: With `psc_owner`=0, a time-out occurs every 256 oscillator ticks whatever the ratio code is.
- R3: With `psc_owner`=0, `tmr_clk` pulses once every 2^(k+1) `tmr_src` pulses, counted from reset (1:2 for code 0 up to 1:256 for code 7). With `psc_owner`=1, each `tmr_src` pulse appears on `tmr_clk` one cycle later, undivided.
- R4: A `wdt_clr` or `sleep_cmd` strobe resets the base counter. When `psc_owner`=1 it also resets the divider count.
- R5: When `psc_owner`=0, a clear strobe leaves the divider count untouched, so the timer division phase carries on.
- R6: A time-out while `asleep`=0 gives `rst_req` as a one-cycle pulse in the cycle after the expiring tick, and `wake_req` stays low.
- R7: A time-out while `asleep`=1 gives `wake_req` instead of `rst_req`, with the same timing. The watchdog keeps counting while asleep.
- R8: `to_n` is 1 after reset. It drops to 0 with each time-out and returns to 1 on the cycle after a clear or sleep strobe.
- R9: While `wdt_en`=0, neither `rst_req` nor `wake_req` is ever produced and `to_n` stays 1.
- R10: When a clear strobe arrives in the same cycle as the expiring tick, the clear wins. No request is given and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_tick | input | 1 | One-cycle tick from the watchdog oscillator |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe; it also clears the watchdog |
| asleep | input | 1 | 1 while the device is in sleep |
| wdt_en | input | 1 | Permanent enable strap; 0 disables the watchdog |
| psc_owner | input | 1 | Divider owner: 1 = watchdog, 0 = timer |
| psc_ratio | input | 3 | Divider tap code |
| tmr_src | input | 1 | Timer source pulse |
| rst_req | output | 1 | Device reset request pulse |
| wake_req | output | 1 | Wake-up request pulse |
| to_n | output | 1 | Time-out flag, active low |
| tmr_clk | output | 1 | Pulse routed to the timer |

## Verification
The assertions assume that `wdt_tick`, `wdt_clr`, `sleep_cmd` and `tmr_src` are synchronous one-cycle enables. They also assume that `psc_owner` and `psc_ratio` are changed only while no time-out is pending. The bench keeps every input change on the falling clock edge. It changes the owner and ratio only right before a clear strobe or a reset, and it toggles `wdt_en` only while the oscillator is idle. This keeps each measured period aligned to a known counter state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    OWN_TIMER = 1'b0,
    OWN_WDT   = 1'b1
  } psc_owner_e;
endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic ovf
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) cnt <= '0;
    else if (tick)         cnt <= cnt + CNT_W'(1);
  end

  assign ovf = en && tick && !clr && (cnt == '1);

  // R9
  base_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));
endmodule

// File: rtl/wdt_shared_psc.sv
module wdt_shared_psc
  import wdt_pkg::*;
#(
  parameter int PSC_W = 8,
  localparam int SEL_W = $clog2(PSC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  psc_owner_e       owner,
  input  logic [SEL_W-1:0] sel,
  input  logic             base_ovf,
  input  logic             tmr_src,
  input  logic             clr,
  output logic             wdt_tap,
  output logic             tmr_clk
);
  logic [PSC_W-1:0] cnt;
  logic [PSC_W:0]   ones;
  logic             ev;
  logic             cnt_clr;
  logic [SEL_W:0]   tsel;

  // ones[i] is set when the low i bits of the count are all 1
  assign ones[0] = 1'b1;
  for (genvar i = 0; i < PSC_W; i++) begin : g_prefix
    assign ones[i+1] = ones[i] & cnt[i];
  end

  assign ev      = (owner == OWN_WDT) ? base_ovf : tmr_src;
  assign cnt_clr = clr && (owner == OWN_WDT);
  assign tsel    = {1'b0, sel} + (SEL_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst || cnt_clr) cnt <= '0;
    else if (ev)        cnt <= cnt + PSC_W'(1);
  end

  assign wdt_tap = (owner == OWN_WDT) ? (base_ovf && ones[sel]) : base_ovf;

  always_ff @(posedge clk) begin
    if (rst) tmr_clk <= 1'b0;
    else     tmr_clk <= (owner == OWN_WDT) ? tmr_src : (tmr_src && ones[tsel]);
  end

  // R4
  psc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && owner == OWN_WDT) |=> (cnt == '0));
  // R5
  psc_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (owner == OWN_TIMER && !tmr_src) |=> $stable(cnt));
endmodule

// File: rtl/wdt_psc_watchdog.sv
module wdt_psc_watchdog
  import wdt_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int PSC_W  = 8,
  localparam int SEL_W = $clog2(PSC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wdt_tick,
  input  logic             wdt_clr,
  input  logic             sleep_cmd,
  input  logic             asleep,
  input  logic             wdt_en,
  input  logic             psc_owner,
  input  logic [SEL_W-1:0] psc_ratio,
  input  logic             tmr_src,
  output logic             rst_req,
  output logic             wake_req,
  output logic             to_n,
  output logic             tmr_clk
);
  logic       any_clr;
  logic       base_ovf;
  logic       tap;
  logic       expire;
  psc_owner_e owner;

  assign any_clr = wdt_clr || sleep_cmd;
  assign owner   = psc_owner_e'(psc_owner);

  wdt_base_cnt #(.CNT_W(BASE_W)) u_base (
    .clk(clk), .rst(rst), .en(wdt_en), .tick(wdt_tick),
    .clr(any_clr), .ovf(base_ovf)
  );

  wdt_shared_psc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .owner(owner), .sel(psc_ratio),
    .base_ovf(base_ovf), .tmr_src(tmr_src), .clr(any_clr),
    .wdt_tap(tap), .tmr_clk(tmr_clk)
  );

  assign expire = tap && !any_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_n     <= 1'b1;
    end else begin
      rst_req  <= expire && !asleep;
      wake_req <= expire && asleep;
      if (any_clr)     to_n <= 1'b1;
      else if (expire) to_n <= 1'b0;
    end
  end

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req));
  // R6
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |=> !(rst_req || wake_req));
  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> (!rst_req && !wake_req && to_n));
  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(to_n) |-> (rst_req || wake_req));
endmodule

// File: tb/wdt_psc_watchdog_test.sv
`timescale 1ns/1ps
module wdt_psc_watchdog_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wdt_tick = 0, wdt_clr = 0, sleep_cmd = 0, asleep = 0;
  logic       wdt_en = 1, psc_owner = 1, tmr_src = 0;
  logic [2:0] psc_ratio = 0;
  logic       rst_req, wake_req, to_n, tmr_clk;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  wdt_psc_watchdog uut (
    .clk(clk), .rst(rst), .wdt_tick(wdt_tick), .wdt_clr(wdt_clr),
    .sleep_cmd(sleep_cmd), .asleep(asleep), .wdt_en(wdt_en),
    .psc_owner(psc_owner), .psc_ratio(psc_ratio), .tmr_src(tmr_src),
    .rst_req(rst_req), .wake_req(wake_req), .to_n(to_n), .tmr_clk(tmr_clk)
  );

  // row: {owner, ratio[2:0], asleep, sleep_strobe, expected_cycles[15:0]}
  localparam logic [21:0] VEC [0:5] = '{
    {1'b1, 3'd0, 1'b0, 1'b0, 16'd256},
    {1'b1, 3'd1, 1'b1, 1'b1, 16'd512},
    {1'b1, 3'd3, 1'b0, 1'b0, 16'd2048},
    {1'b0, 3'd5, 1'b0, 1'b0, 16'd256},
    {1'b0, 3'd7, 1'b1, 1'b1, 16'd256},
    {1'b1, 3'd7, 1'b1, 1'b0, 16'd32768}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; wdt_tick = 0; wdt_clr = 0; sleep_cmd = 0; tmr_src = 0;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic strobe(input bit use_sleep);
    wdt_clr = !use_sleep; sleep_cmd = use_sleep;
    @(negedge clk);
    wdt_clr = 0; sleep_cmd = 0;
  endtask

  task automatic run_to(input bit use_sleep, input int limit, output int n);
    @(negedge clk);
    wdt_tick = 0;
    strobe(use_sleep);
    wdt_tick = 1; n = 0;
    while (!(rst_req || wake_req) && n < limit) begin
      @(negedge clk); n++;
    end
    wdt_tick = 0;
  endtask

  task automatic ticks(input int k);
    wdt_tick = 1;
    repeat (k) @(negedge clk);
    wdt_tick = 0;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    int cnt;
    do_reset();
    @(negedge clk);
    chk("R8 reset to_n", to_n, 1);
    chk("R6 reset rst_req", rst_req, 0);
    chk("R7 reset wake_req", wake_req, 0);
    chk("R3 reset tmr_clk", tmr_clk, 0);

    foreach (VEC[i]) begin
      psc_owner = VEC[i][21];
      psc_ratio = VEC[i][20:18];
      asleep    = VEC[i][17];
      run_to(VEC[i][16], 40000, n);
      chk(psc_owner ? "R1 period" : "R2 period", n, int'(VEC[i][15:0]));
      chk("R6 reset request", rst_req, !asleep);
      chk("R7 wake request", wake_req, asleep);
      chk("R8 to_n low on time-out", to_n, 0);
      @(negedge clk);
      chk("R6 one-cycle pulse", rst_req || wake_req, 0);
      strobe(VEC[i][16]);
      chk("R8 to_n set by strobe", to_n, 1);
    end
    asleep = 0;

    // R9: disabled watchdog
    psc_owner = 1; psc_ratio = 0; wdt_en = 0;
    run_to(1'b0, 600, n);
    chk("R9 no time-out when disabled", n, 600);
    chk("R9 to_n stays high", to_n, 1);
    wdt_en = 1;

    // R10: clear in the expiring cycle
    strobe(1'b0);
    ticks(255);
    wdt_tick = 1; wdt_clr = 1;
    @(negedge clk);
    wdt_tick = 0; wdt_clr = 0;
    chk("R10 no request on collision", rst_req, 0);
    chk("R10 to_n high on collision", to_n, 1);
    ticks(255);
    chk("R10 count restarted", rst_req, 0);
    ticks(1);
    chk("R10 expires 256 after clear", rst_req, 1);

    // R4: divider cleared on the watchdog path
    psc_ratio = 1;
    @(negedge clk);
    strobe(1'b0);
    ticks(256);
    chk("R4 first overflow divided", rst_req, 0);
    strobe(1'b0);
    ticks(256);
    chk("R4 divider restarted by clear", rst_req, 0);
    ticks(256);
    chk("R4 second overflow expires", rst_req, 1);

    // R3: timer path division
    for (int k = 0; k < 6; k += 1) begin
      do_reset();
      psc_owner = 0; psc_ratio = 3'(k);
      cnt = 0;
      tmr_src = 1;
      repeat (64) begin
        @(negedge clk);
        if (tmr_clk) cnt++;
      end
      tmr_src = 0;
      chk("R3 timer division", cnt, 64 >> (k + 1));
    end

    // R3: pass-through with watchdog ownership
    do_reset();
    psc_owner = 1; psc_ratio = 3'd4;
    cnt = 0; tmr_src = 1;
    repeat (10) begin
      @(negedge clk);
      if (tmr_clk) cnt++;
    end
    tmr_src = 0;
    chk("R3 undivided pass-through", cnt, 10);

    // R5: clear leaves the timer divider phase
    do_reset();
    psc_owner = 0; psc_ratio = 3'd1;
    cnt = 0; tmr_src = 1;
    repeat (3) begin
      @(negedge clk);
      if (tmr_clk) cnt++;
    end
    tmr_src = 0;
    chk("R5 no tick before fourth pulse", cnt, 0);
    strobe(1'b0);
    tmr_src = 1;
    @(negedge clk);
    tmr_src = 0;
    chk("R5 fourth pulse ticks after clear", tmr_clk, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule